// File: doc/BRIEF.md
# Shadow RAM Memory Decoder

This block decodes the 16-bit address bus of an 8-bit processor into active-low chip selects for one RAM, one firmware ROM and four I/O devices. It also produces a write strobe and an output-enable strobe, both gated by the high half of the processor clock phase. A wait-state request goes out whenever the ROM or an I/O device marked as slow is selected.

The firmware window covers 0xC000–0xFDFF and 0xFF00–0xFFFF. Page 0xFE is held back for I/O. The window runs in one of two modes. After reset it is in ROM mode: reads there go to ROM, and writes fall through to the RAM beneath. Boot code can therefore read each firmware byte and write it back to the same address, which fills the shadow copy. Software then sets a control bit and the block enters RAM mode. From then on RAM serves the whole window, and a second control bit can make the shadow copy read-only. Both bits live in a one-byte control location at 0xFE3F. Only data lines 1..0 feed the block.

Top module: `shadow_mem_decoder`

## Requirements
- R1: Any address below 0xC000 asserts only the RAM select, for reads and for writes, in either mode.
- R2: Select k of the four I/O selects (k = 0..3) is low exactly for addresses 0xFE00+16k through 0xFE0F+16k. Addresses 0xFE40–0xFEFF assert no chip select at all.
- R3: The read strobe is low exactly when the clock phase is high and the cycle is a read. The write strobe is low exactly when the clock phase is high and the cycle is a write, except for the protected case in R9.
- R4: For every input combination, no more than one chip select is low.
- R5: Reset clears both control bits. With the RAM-mode bit clear, a read of the firmware window asserts the ROM select only.
- R6: With the RAM-mode bit clear, a write to the firmware window asserts the RAM select and leaves the ROM select high.
- R7: A write to 0xFE3F with the clock phase high is captured on the next rising clock edge. Data bit 0 is the RAM-mode bit and bit 1 is the write-protect bit. The values apply from that edge onward. A write to 0xFE3F with the clock phase low leaves the control bits unchanged.
- R8: With the RAM-mode bit set, reads of the firmware window assert the RAM select, and the ROM select never goes low.
- R9: With both control bits set, a write to the firmware window asserts no chip select and keeps the write strobe high.
- R10: With the RAM-mode bit clear, the write-protect bit has no effect. Firmware writes still reach RAM with the write strobe asserted.
- R11: The wait request is high exactly when the ROM select is low or an I/O select flagged in the slow mask (default: I/O 2 and I/O 3) is low. It is never high during a RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the control location is captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor clock phase; high marks the data half of the bus cycle |
| cpu_read | input | 1 | 1 = read cycle, 0 = write cycle |
| addr | input | 16 | Processor address bus |
| ctrl_data | input | 2 | Data lines 1..0; bit 0 = RAM mode, bit 1 = write protect |
| ram_sel_n | output | 1 | RAM chip select, active low |
| rom_sel_n | output | 1 | ROM chip select, active low |
| io_sel_n | output | 4 | I/O chip selects, active low, bit k for I/O k |
| wr_strobe_n | output | 1 | Write strobe, active low |
| rd_strobe_n | output | 1 | Output-enable strobe, active low |
| wait_req | output | 1 | Wait-state request, active high |

## Verification
The only internal state is the two control bits, so a fault there shows up at the ports in the very next firmware-window access. A mode bit stuck clear leaves the ROM select low on firmware reads after the switch. A lost protect bit lets the write strobe and the RAM select through on a firmware write. A bit that sets too early or late by one edge moves that change to the wrong cycle. The bench therefore follows every control write with window accesses in the next cycle, in both modes and in both protect states. It also checks that a reset in the middle of a run brings ROM back for firmware reads.

// File: rtl/smd_pkg.sv
package smd_pkg;

  typedef enum logic [1:0] {
    RG_RAM  = 2'd0,
    RG_FW   = 2'd1,
    RG_IO   = 2'd2,
    RG_NONE = 2'd3
  } region_t;

  typedef struct packed {
    logic wprot;
    logic ram_mode;
  } ctrl_t;

  // Region classification from address bits only.
  // RAM needs bits 15..14, the I/O page needs 15..8 and 7..6.
  function automatic region_t classify(input logic [15:0] a);
    region_t r;
    if (a[15:14] != 2'b11)        r = RG_RAM;
    else if (a[15:8] != 8'hFE)    r = RG_FW;
    else if (a[7:6] == 2'b00)     r = RG_IO;
    else                          r = RG_NONE;
    return r;
  endfunction

  function automatic logic [1:0] io_slot(input logic [15:0] a);
    return a[5:4];
  endfunction

endpackage

// File: rtl/smd_region_decode.sv
module smd_region_decode
  import smd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IO_NUM = 4,
  localparam int IDX_W = $clog2(IO_NUM)
) (
  input  logic [ADDR_W-1:0] addr,
  output region_t           region,
  output logic [IDX_W-1:0]  io_idx
);
  always_comb begin
    region = classify(addr);
    io_idx = io_slot(addr);
  end
endmodule

// File: rtl/smd_ctrl_reg.sv
module smd_ctrl_reg
  import smd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CTRL_ADDR = 16'hFE3F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cpu_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctrl_data,
  output ctrl_t             ctrl_q
);
  logic load;
  assign load = phi2 && !cpu_read && (addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (load) begin
      ctrl_q.ram_mode <= ctrl_data[0];
      ctrl_q.wprot    <= ctrl_data[1];
    end
  end
endmodule

// File: rtl/smd_select_gen.sv
module smd_select_gen
  import smd_pkg::*;
#(
  parameter int               IO_NUM    = 4,
  parameter logic [IO_NUM-1:0] SLOW_MASK = 4'b1100,
  localparam int IDX_W = $clog2(IO_NUM)
) (
  input  region_t           region,
  input  logic [IDX_W-1:0]  io_idx,
  input  ctrl_t             ctrl,
  input  logic              phi2,
  input  logic              cpu_read,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic [IO_NUM-1:0] io_sel_n,
  output logic              wr_strobe_n,
  output logic              rd_strobe_n,
  output logic              wait_req,
  output logic              fw_blocked
);
  logic in_fw, rom_hit, fw_to_ram;
  logic [IO_NUM-1:0] io_hit;

  always_comb begin
    in_fw      = (region == RG_FW);
    rom_hit    = in_fw && cpu_read && !ctrl.ram_mode;
    fw_blocked = in_fw && !cpu_read && ctrl.ram_mode && ctrl.wprot;
    fw_to_ram  = in_fw && !rom_hit && !fw_blocked;
  end

  for (genvar k = 0; k < IO_NUM; k++) begin : g_io
    assign io_hit[k] = (region == RG_IO) && (io_idx == IDX_W'(k));
  end

  always_comb begin
    ram_sel_n   = !((region == RG_RAM) || fw_to_ram);
    rom_sel_n   = !rom_hit;
    io_sel_n    = ~io_hit;
    rd_strobe_n = !(phi2 && cpu_read);
    wr_strobe_n = !(phi2 && !cpu_read && !fw_blocked);
    wait_req    = rom_hit || |(io_hit & SLOW_MASK);
  end
endmodule

// File: rtl/shadow_mem_decoder.sv
module shadow_mem_decoder
  import smd_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter int               IO_NUM    = 4,
  parameter logic [IO_NUM-1:0] SLOW_MASK = 4'b1100,
  parameter logic [15:0]      CTRL_ADDR = 16'hFE3F,
  localparam int IDX_W = $clog2(IO_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              cpu_read,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctrl_data,
  output logic              ram_sel_n,
  output logic              rom_sel_n,
  output logic [IO_NUM-1:0] io_sel_n,
  output logic              wr_strobe_n,
  output logic              rd_strobe_n,
  output logic              wait_req
);
  region_t          region;
  logic [IDX_W-1:0] io_idx;
  ctrl_t            ctrl_q;

  // named internal events for the checker
  logic ram_mode_w, wprot_w, fw_blocked_w;
  assign ram_mode_w = ctrl_q.ram_mode;
  assign wprot_w    = ctrl_q.wprot;

  smd_region_decode #(.ADDR_W(ADDR_W), .IO_NUM(IO_NUM)) u_dec (
    .addr(addr), .region(region), .io_idx(io_idx)
  );

  smd_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_read(cpu_read),
    .addr(addr), .ctrl_data(ctrl_data), .ctrl_q(ctrl_q)
  );

  smd_select_gen #(.IO_NUM(IO_NUM), .SLOW_MASK(SLOW_MASK)) u_sel (
    .region(region), .io_idx(io_idx), .ctrl(ctrl_q),
    .phi2(phi2), .cpu_read(cpu_read),
    .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n),
    .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n),
    .wait_req(wait_req), .fw_blocked(fw_blocked_w)
  );
endmodule

// File: rtl/smd_checker.sv
module smd_checker #(
  parameter int               IO_NUM    = 4,
  parameter logic [IO_NUM-1:0] SLOW_MASK = 4'b1100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phi2,
  input logic              cpu_read,
  input logic [15:0]       addr,
  input logic [1:0]        ctrl_data,
  input logic              ram_sel_n,
  input logic              rom_sel_n,
  input logic [IO_NUM-1:0] io_sel_n,
  input logic              wr_strobe_n,
  input logic              rd_strobe_n,
  input logic              wait_req,
  input logic              ram_mode,
  input logic              wprot
);
  logic fw_addr;
  assign fw_addr = (addr >= 16'hC000) && (addr[15:8] != 8'hFE);

  p_low_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < 16'hC000) |-> (!ram_sel_n && rom_sel_n && &io_sel_n));

  p_rd_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n) == (phi2 && cpu_read));

  p_one_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ram_sel_n, ~rom_sel_n, ~io_sel_n}) <= 1);

  p_rom_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_mode && fw_addr && cpu_read) |-> !rom_sel_n);

  p_fallthrough_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_mode && fw_addr && !cpu_read) |-> (!ram_sel_n && rom_sel_n));

  p_ctrl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_read && addr == 16'hFE3F) |=>
      (ram_mode == $past(ctrl_data[0]) && wprot == $past(ctrl_data[1])));

  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && !cpu_read && addr == 16'hFE3F) |=> ($stable(ram_mode) && $stable(wprot)));

  p_no_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_mode |-> rom_sel_n);

  p_protect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_mode && wprot && fw_addr && !cpu_read) |-> (ram_sel_n && wr_strobe_n));

  p_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wait_req == (!rom_sel_n || |(~io_sel_n & SLOW_MASK)));

  p_ram_nowait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_sel_n |-> !wait_req);
endmodule

bind shadow_mem_decoder smd_checker #(.IO_NUM(IO_NUM), .SLOW_MASK(SLOW_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_read(cpu_read),
  .addr(addr), .ctrl_data(ctrl_data),
  .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n),
  .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n), .wait_req(wait_req),
  .ram_mode(ram_mode_w), .wprot(wprot_w)
);

// File: tb/shadow_mem_decoder_tb.sv
`timescale 1ns/1ps
module shadow_mem_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0;
  logic        cpu_read = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [1:0]  ctrl_data = 2'b00;
  logic        ram_sel_n, rom_sel_n, wr_strobe_n, rd_strobe_n, wait_req;
  logic [3:0]  io_sel_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  // bench model of the control bits
  bit m_ram = 1'b0;
  bit m_wp  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shadow_mem_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_read(cpu_read),
    .addr(addr), .ctrl_data(ctrl_data),
    .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n), .io_sel_n(io_sel_n),
    .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n), .wait_req(wait_req)
  );

  // expected {ram_n, rom_n, io_n[3:0], wr_n, rd_n, wait}
  function automatic logic [8:0] expect_out(input logic [15:0] a, input bit rd,
                                            input bit ph, input bit rmode, input bit wp);
    bit ram = 0, rom = 0, blk = 0, slow = 0;
    logic [3:0] io = 4'b0000;
    bit fw = (a >= 16'hC000) && !(a >= 16'hFE00 && a <= 16'hFEFF);
    if (a < 16'hC000) ram = 1;
    for (int k = 0; k < 4; k++)
      if (a >= 16'hFE00 + 16*k && a <= 16'hFE0F + 16*k) io[k] = 1'b1;
    if (fw) begin
      if (rd && !rmode)          rom = 1;
      else if (!rd && rmode && wp) blk = 1;
      else                        ram = 1;
    end
    slow = io[2] || io[3];
    return {!ram, !rom, ~io, !(ph && !rd && !blk), !(ph && rd), rom || slow};
  endfunction

  task automatic step(input logic [15:0] a, input bit rd, input bit ph,
                      input logic [1:0] d, input string req);
    logic [8:0] exp_v, got;
    @(negedge clk);
    addr = a; cpu_read = rd; phi2 = ph; ctrl_data = d;
    #2;
    exp_v = expect_out(a, rd, ph, m_ram, m_wp);
    got = {ram_sel_n, rom_sel_n, io_sel_n, wr_strobe_n, rd_strobe_n, wait_req};
    n_tests++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s addr=%h rd=%0b ph=%0b actual=%b expected=%b", req, a, rd, ph, got, exp_v);
    end
    @(posedge clk);
    if (rst_n && ph && !rd && a == 16'hFE3F) begin m_ram = d[0]; m_wp = d[1]; end
    #1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra;
    bit rrd, rph;
    logic [1:0] rd2;
    int unsigned seed = 32'd1234;
    void'($urandom(seed));

    // R5: reset state, firmware read goes to ROM
    step(16'hC000, 1, 1, 2'b00, "R5 reset rom read");
    @(negedge clk); rst_n = 1'b1;

    step(16'h0000, 1, 1, 2'b00, "R1 low ram read");
    step(16'hBFFF, 0, 1, 2'b00, "R1 top ram write");
    step(16'hFE00, 1, 1, 2'b00, "R2 io0 low");
    step(16'hFE1F, 1, 0, 2'b00, "R2 io1 high");
    step(16'hFE25, 1, 1, 2'b00, "R2 io2 R11 slow wait");
    step(16'hFE40, 1, 1, 2'b00, "R2 unmapped io page");
    step(16'hFEFF, 0, 1, 2'b00, "R2 unmapped top");
    step(16'hFDFF, 1, 1, 2'b00, "R5 fw read rom");
    step(16'hFF00, 0, 1, 2'b00, "R6 fw write falls to ram");
    step(16'hFFFF, 0, 0, 2'b00, "R3 write phase low");
    // R10: protect set while still in ROM mode
    step(16'hFE3F, 0, 1, 2'b10, "R7 load wp only");
    step(16'hE000, 0, 1, 2'b00, "R10 wp ignored in rom mode");
    // R7: write with phase low must not load
    step(16'hFE3F, 0, 0, 2'b01, "R7 phase low ignored");
    step(16'hC123, 1, 1, 2'b00, "R7 still rom mode");
    // switch to RAM mode without protect
    step(16'hFE3F, 0, 1, 2'b01, "R7 load ram mode");
    step(16'hC123, 1, 1, 2'b00, "R8 fw read ram");
    step(16'hFFFC, 0, 1, 2'b00, "R8 fw write ram");
    // enable protect
    step(16'hFE3F, 0, 1, 2'b11, "R7 load ram+wp");
    step(16'hD000, 0, 1, 2'b00, "R9 protected write");
    step(16'hD000, 1, 1, 2'b00, "R9 protected read ok");
    step(16'h1234, 0, 1, 2'b00, "R1 ram write unaffected by wp");
    step(16'hFE35, 0, 1, 2'b00, "R2 io3 write");
    // mid-run reset returns to ROM mode
    @(negedge clk); rst_n = 1'b0; m_ram = 0; m_wp = 0;
    @(negedge clk); rst_n = 1'b1;
    step(16'hF800, 1, 1, 2'b00, "R5 rom after reset");

    // constrained random mix, checks R1 R2 R3 R4 R6 R8 R9 R11
    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 4))
        0: ra = 16'($urandom_range(0, 16'hBFFF));
        1: ra = 16'($urandom_range(16'hC000, 16'hFDFF));
        2: ra = 16'hFE00 | 16'($urandom_range(0, 255));
        3: ra = 16'hFF00 | 16'($urandom_range(0, 255));
        default: ra = 16'hFE3F;
      endcase
      rrd = 1'($urandom_range(0, 1));
      rph = 1'($urandom_range(0, 1));
      rd2 = 2'($urandom_range(0, 3));
      step(ra, rrd, rph, rd2, "R4 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule